// File: doc/BRIEF.md
# Channel Readout Byte Formatter

This block assembles the bytes handed back when software reads one converter channel's status register or its result register. When a read request is accepted, it takes one snapshot of all of its inputs. From that snapshot it builds a status byte: the channel number, two bits that carry either the port-pin levels or the ready flag, and the reference, polarity and range flags. It also formats the conversion result as 16 or 24 bits, and can clamp the result when the input is out of range. The frame then leaves the block one byte per transfer, most-significant byte first, and the final byte is marked. A separate serial shifter, outside this block, consumes the byte stream.

The mode inputs decide which bytes a frame holds. With no special mode, a status read returns only the status byte and a data read returns only the data bytes. With the dump bit set, either read returns the status byte followed at once by the data bytes. Continuous-read mode always uses the dump ordering, whatever the dump bit says.

Both edges of the block are valid/ready. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the last byte of the frame has been transferred. On the output side, a byte moves when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_byte` and `out_last` hold their values. The first byte of a frame appears in the cycle after the request is accepted.

Top module: `readout_formatter`

## Requirements
- R1: Status byte bits 7..5 carry the requested channel number, so that channel n's status byte always equals n*20h plus its low five bits.
- R2: Status bit 4 is 0 when the status option is clear, and equals the level of pin 0 when the option is set.
- R3: Status bit 3 equals the channel ready flag when the status option is clear, and equals the level of pin 1 when the option is set.
- R4: Status bit 2 is the missing-reference flag, bit 1 is the polarity (1 = negative) and bit 0 is the out-of-range flag.
- R5: With the width bit at 1, data is three bytes holding the 24-bit result. With the width bit at 0, data is two bytes holding the result's top 16 bits. Data bytes are sent most-significant first.
- R6: With clamping enabled and the out-of-range flag set, the data is all ones when the polarity bit is 0 (over-range) and all zeros when it is 1 (under-range). Otherwise the raw result is sent.
- R7: With neither dump nor continuous read set, a status read gives exactly one byte and a data read gives only the data bytes.
- R8: With dump set, a read of either register gives the status byte followed immediately by the data bytes.
- R9: With continuous read set, every read uses the dump ordering, whether or not the dump bit is set.
- R10: Every input is sampled in the acceptance cycle. The first byte is valid in the next cycle. `out_byte` and `out_last` hold while `out_ready` is low. `out_last` marks the final byte. `req_ready` is low while a frame is in flight.
- R11: During reset and immediately after it, `out_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_sel_data | input | 1 | 1 = result register read, 0 = status register read |
| req_chan | input | 3 | Channel number of the read |
| stat_opt | input | 1 | Status option of the addressed channel: 1 shows the pins |
| pin0 | input | 1 | Port pin 0 level |
| pin1 | input | 1 | Port pin 1 level |
| chan_rdy | input | 1 | Ready flag of the addressed channel |
| no_ref | input | 1 | Reference missing |
| in_negative | input | 1 | Input polarity, 1 = negative |
| out_of_range | input | 1 | Input outside the nominal range |
| raw_result | input | 24 | Raw conversion result |
| dump_en | input | 1 | Dump mode: status precedes data |
| cont_read | input | 1 | Continuous-read mode |
| wide_en | input | 1 | 1 = 24-bit data, 0 = 16-bit data |
| clamp_en | input | 1 | Clamp out-of-range results |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Current byte of the frame |
| out_last | output | 1 | Current byte ends the frame |

## Verification
The stimulus drives `out_ready` low often, so frames stall part-way through. A design that advanced on valid alone would drop bytes or send a byte twice. The mode, flag and result inputs change every cycle while a frame is being sent. A block that did not keep its acceptance snapshot would mix fields from different reads. The random requests cover the clamp cases in both polarities, including the 16-bit form. A clamp of the wrong polarity, or one that did not reach the narrowed result, shows up as a data-byte mismatch. The runs also include continuous read with the dump bit cleared, which catches frame lengths that ignore the forced dump ordering. The status option is toggled against differing pin and ready levels, which exposes swapped or unmultiplexed status bits.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAN_W = 3;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              pin0_sel;
    logic              pin1_sel;
    logic              ref_missing;
    logic              negative;
    logic              range_err;
  } status_byte_t;
endpackage

// File: rtl/readout_status_compose.sv
module readout_status_compose
  import readout_pkg::*;
(
  input  logic [CHAN_W-1:0] chan,
  input  logic              opt,
  input  logic              pin0,
  input  logic              pin1,
  input  logic              rdy,
  input  logic              no_ref,
  input  logic              negative,
  input  logic              range_err,
  output status_byte_t      status
);
  always_comb begin
    status.chan        = chan;
    status.pin0_sel    = opt ? pin0 : 1'b0;
    status.pin1_sel    = opt ? pin1 : rdy;
    status.ref_missing = no_ref;
    status.negative    = negative;
    status.range_err   = range_err;
  end
endmodule

// File: rtl/readout_data_format.sv
module readout_data_format #(
  parameter int RES_W    = 24,
  parameter int NARROW_W = 16
) (
  input  logic [RES_W-1:0] raw,
  input  logic             wide,
  input  logic             clamp,
  input  logic             range_err,
  input  logic             negative,
  output logic [RES_W-1:0] data_lj
);
  logic [RES_W-1:0] limited;
  logic [RES_W-1:0] narrowed;

  always_comb begin
    if (clamp && range_err)
      limited = negative ? '0 : '1;
    else
      limited = raw;
  end

  generate
    if (NARROW_W >= RES_W) begin : g_same
      assign narrowed = limited;
    end else begin : g_trunc
      assign narrowed = {limited[RES_W-1 -: NARROW_W], {(RES_W-NARROW_W){1'b0}}};
    end
  endgenerate

  assign data_lj = wide ? limited : narrowed;
endmodule

// File: rtl/readout_byte_sequencer.sv
module readout_byte_sequencer
  import readout_pkg::*;
#(
  parameter int FRAME_BYTES = 4,
  localparam int FRAME_W = FRAME_BYTES * BYTE_W,
  localparam int CNT_W   = $clog2(FRAME_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   count,
  output logic               idle,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_byte,
  output logic               out_last
);
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   left_q;

  assign out_valid = (left_q != '0);
  assign idle      = (left_q == '0);
  assign out_byte  = frame_q[FRAME_W-1 -: BYTE_W];
  assign out_last  = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      left_q  <= '0;
    end else if (load && idle) begin
      frame_q <= frame;
      left_q  <= count;
    end else if (out_valid && out_ready) begin
      frame_q <= frame_q << BYTE_W;
      left_q  <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/readout_formatter.sv
module readout_formatter
  import readout_pkg::*;
#(
  parameter int RES_W    = 24,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sel_data,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              stat_opt,
  input  logic              pin0,
  input  logic              pin1,
  input  logic              chan_rdy,
  input  logic              no_ref,
  input  logic              in_negative,
  input  logic              out_of_range,
  input  logic [RES_W-1:0]  raw_result,
  input  logic              dump_en,
  input  logic              cont_read,
  input  logic              wide_en,
  input  logic              clamp_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_last
);
  localparam int WIDE_BYTES   = RES_W / BYTE_W;
  localparam int NARROW_BYTES = NARROW_W / BYTE_W;
  localparam int FRAME_BYTES  = 1 + WIDE_BYTES;
  localparam int FRAME_W      = FRAME_BYTES * BYTE_W;
  localparam int CNT_W        = $clog2(FRAME_BYTES + 1);

  status_byte_t      status;
  logic [RES_W-1:0]  data_lj;
  logic              with_status;
  logic              with_data;
  logic [CNT_W-1:0]  data_cnt;
  logic [CNT_W-1:0]  frame_cnt;
  logic [FRAME_W-1:0] frame;
  logic              seq_idle;

  readout_status_compose u_status (
    .chan      (req_chan),
    .opt       (stat_opt),
    .pin0      (pin0),
    .pin1      (pin1),
    .rdy       (chan_rdy),
    .no_ref    (no_ref),
    .negative  (in_negative),
    .range_err (out_of_range),
    .status    (status)
  );

  readout_data_format #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_data (
    .raw       (raw_result),
    .wide      (wide_en),
    .clamp     (clamp_en),
    .range_err (out_of_range),
    .negative  (in_negative),
    .data_lj   (data_lj)
  );

  always_comb begin
    with_status = dump_en || cont_read || !req_sel_data;
    with_data   = dump_en || cont_read || req_sel_data;
    data_cnt    = with_data ? (wide_en ? CNT_W'(WIDE_BYTES) : CNT_W'(NARROW_BYTES)) : '0;
    frame_cnt   = data_cnt + (with_status ? CNT_W'(1) : CNT_W'(0));
    if (with_status)
      frame = {status, data_lj};
    else
      frame = {data_lj, {BYTE_W{1'b0}}};
  end

  readout_byte_sequencer #(.FRAME_BYTES(FRAME_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_valid),
    .frame     (frame),
    .count     (frame_cnt),
    .idle      (seq_idle),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last)
  );

  assign req_ready = seq_idle;
endmodule

// File: rtl/readout_formatter_checker.sv
module readout_formatter_checker
  import readout_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_sel_data,
  input logic [CHAN_W-1:0] req_chan,
  input logic              dump_en,
  input logic              cont_read,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_last
);
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

  assert_busy_blocks_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  assert_first_byte_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid);

  assert_frame_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  assert_chan_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (dump_en || cont_read)
      |=> out_byte[7:5] == $past(req_chan));

  assert_status_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dump_en && !cont_read && !req_sel_data |=> out_last);

  assert_cont_forces_dump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cont_read && !dump_en |=> !out_last);
endmodule

bind readout_formatter readout_formatter_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_sel_data (req_sel_data),
  .req_chan     (req_chan),
  .dump_en      (dump_en),
  .cont_read    (cont_read),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_byte     (out_byte),
  .out_last     (out_last)
);

// File: tb/readout_formatter_test.sv
module readout_formatter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_sel_data;
  logic [2:0]  req_chan;
  logic        stat_opt, pin0, pin1, chan_rdy, no_ref, in_negative, out_of_range;
  logic [23:0] raw_result;
  logic        dump_en, cont_read, wide_en, clamp_en;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_byte;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] exp_byte[$];
  bit         exp_last[$];
  string      exp_tag[$];

  always #10 clk = ~clk;

  readout_formatter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel_data(req_sel_data), .req_chan(req_chan), .stat_opt(stat_opt),
    .pin0(pin0), .pin1(pin1), .chan_rdy(chan_rdy), .no_ref(no_ref),
    .in_negative(in_negative), .out_of_range(out_of_range), .raw_result(raw_result),
    .dump_en(dump_en), .cont_read(cont_read), .wide_en(wide_en), .clamp_en(clamp_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model: queue the expected bytes of one frame.
  task automatic push_frame();
    int st, val, nbytes;
    bit has_st, has_dat;
    string dtag, ltag;
    st = req_chan * 32;
    if (stat_opt) st += pin0 * 16 + pin1 * 8;
    else          st += chan_rdy * 8;
    st += no_ref * 4 + in_negative * 2 + out_of_range;
    val = raw_result;
    dtag = "R5";
    if (clamp_en && out_of_range) begin
      val  = in_negative ? 0 : 24'hFFFFFF;
      dtag = "R6";
    end
    has_st  = dump_en || cont_read || !req_sel_data;
    has_dat = dump_en || cont_read || req_sel_data;
    ltag = cont_read ? "R9" : (dump_en ? "R8" : "R7");
    nbytes = wide_en ? 3 : 2;
    if (has_st) begin
      exp_byte.push_back(8'(st));
      exp_last.push_back(!has_dat);
      exp_tag.push_back($sformatf("R1 R2 R3 R4 %s", ltag));
    end
    if (has_dat)
      for (int i = 0; i < nbytes; i++) begin
        exp_byte.push_back(8'(val >> (16 - 8 * i)));
        exp_last.push_back(i == nbytes - 1);
        exp_tag.push_back($sformatf("%s %s", dtag, ltag));
      end
  endtask

  task automatic compare_outputs();
    bit ev;
    ev = exp_byte.size() > 0;
    chk(out_valid == ev, "R10", "out_valid", out_valid, ev);
    chk(req_ready == !ev, "R10", "req_ready", req_ready, !ev);
    if (ev && out_valid) begin
      chk(out_byte == exp_byte[0], exp_tag[0], "out_byte", out_byte, exp_byte[0]);
      chk(out_last == exp_last[0], exp_tag[0], "out_last", out_last, exp_last[0]);
    end
  endtask

  task automatic drive_random(input int ready_pct, input int valid_pct);
    req_valid    = ($urandom % 100) < valid_pct;
    req_sel_data = $urandom % 2;
    req_chan     = 3'($urandom);
    stat_opt     = $urandom % 2;
    pin0         = $urandom % 2;
    pin1         = $urandom % 2;
    chan_rdy     = $urandom % 2;
    no_ref       = $urandom % 2;
    in_negative  = $urandom % 2;
    out_of_range = ($urandom % 3) == 0;
    raw_result   = 24'($urandom);
    dump_en      = $urandom % 2;
    cont_read    = ($urandom % 4) == 0;
    wide_en      = $urandom % 2;
    clamp_en     = $urandom % 2;
    out_ready    = ($urandom % 100) < ready_pct;
  endtask

  task automatic step_model();
    if (out_valid && out_ready && exp_byte.size() > 0) begin
      void'(exp_byte.pop_front());
      void'(exp_last.pop_front());
      void'(exp_tag.pop_front());
    end
    if (req_valid && req_ready) push_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive_random(50, 50);
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
      chk(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
    end
    rst_n = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    chk(req_ready == 1'b1, "R11", "req_ready after reset", req_ready, 1);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      drive_random(cyc < 3000 ? 60 : 100, 60);
      step_model();
      @(negedge clk);
      compare_outputs();
    end
    req_valid = 1'b0;
    out_ready = 1'b1;
    for (int cyc = 0; cyc < 10; cyc++) begin
      step_model();
      @(negedge clk);
      compare_outputs();
    end
    chk(exp_byte.size() == 0, "R10", "frame drained", exp_byte.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule